// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the fetch side of a simple processor front end. It keeps a small first-in first-out queue of instruction bytes filled ahead of the execute side. It holds a 16-bit code segment value and a 16-bit instruction offset. From these it forms a 20-bit physical fetch address: the segment shifted left by four bits plus the offset. It issues single-byte reads on a request/grant memory port, and read data comes back later, in order, on a response strobe.

The consumer takes bytes through a valid/ready pop port. Fetching goes on while the consumer holds earlier bytes, so fetch overlaps execution. A redirect input loads a new segment and offset, empties the queue, and marks every read still in flight as stale. Stale data is thrown away when it returns.

Top module: `ipq_prefetch_unit`

## Requirements
- R1: After reset the queue is empty (`pop_valid_o` low), `mem_req_o` is high, and `mem_addr_o` equals RESET_SEG*16 + RESET_OFF modulo 2^20.
- R2: `mem_addr_o` equals segment*16 + offset modulo 2^20. For example, segment 4321h with offset 1000h gives 44210h, and segment FFFFh with offset 0010h gives 00000h.
- R3: Each accepted read (`mem_req_o` and `mem_gnt_i` high at a clock edge) advances the offset by one modulo 2^16, so offset FFFFh is followed by 0000h. While a request waits for grant, its address is held.
- R4: Bytes leave on `pop_data_o` in the order their reads were accepted. A byte that is offered but not taken stays on the port.
- R5: A read is requested only when the redirect input is low, queue occupancy plus live reads in flight is below DEPTH (default 6), and total outstanding reads, stale ones included, are below MAX_PEND. The queue never holds more than DEPTH bytes.
- R6: A redirect (`redir_i` high at an edge) loads the segment and offset from `redir_seg_i` and `redir_off_i` and empties the queue. In the cycle after it, `pop_valid_o` is low and the next request uses the new address.
- R7: A response to a read accepted before a redirect, including one that arrives in the redirect cycle itself, is discarded and never enqueued.
- R8: While `redir_i` is high, `pop_valid_o` is low. A pop cannot complete in the same cycle as a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redir_i | input | 1 | Redirect: load new segment/offset and flush |
| redir_seg_i | input | 16 | New code segment value |
| redir_off_i | input | 16 | New instruction offset |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 20 | Physical address of the requested byte |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data returned (in request order) |
| mem_rdata_i | input | 8 | Returned byte |
| pop_valid_o | output | 1 | Queue head byte available |
| pop_data_o | output | 8 | Queue head byte |
| pop_ready_i | input | 1 | Consumer takes the head byte |

## Verification
The bench builds the unit with DEPTH=6, MAX_PEND=16, RESET_SEG=FFFFh and RESET_OFF=0000h. The reset address is FFFF0h, so sixteen fetches after reset carry the 20-bit sum past its top and wrap it to 00000h. Redirects to offset FFFEh reach the 16-bit offset wrap. With a memory that grants and answers at random, redirects often land while several reads are in flight, so stale responses, including ones in the redirect cycle, are common. Long consumer stalls fill all six slots, which tests the room rule.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned SHIFT_W = 4;
  localparam int unsigned PA_W    = 20;
  localparam int unsigned BYTE_W  = 8;

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [PA_W-1:0]   paddr_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ipq_addr_gen.sv
module ipq_addr_gen
  import ipq_pkg::*;
(
  input  seg_t   seg_i,
  input  off_t   off_i,
  output paddr_t paddr_o
);
  localparam int unsigned SUM_W = (SEG_W + SHIFT_W > OFF_W) ? SEG_W + SHIFT_W : OFF_W;

  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    seg_ext = SUM_W'({seg_i, {SHIFT_W{1'b0}}});
    off_ext = SUM_W'(off_i);
    sum     = seg_ext + off_ext;
    paddr_o = sum[PA_W-1:0];  // modulo 2^PA_W
  end
endmodule

// File: rtl/ipq_fifo.sv
module ipq_fifo #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push_i && !flush_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i  && !flush_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  assign dout_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl
  import ipq_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned MAX_PEND  = 16,
  parameter seg_t        RESET_SEG = 16'hFFFF,
  parameter off_t        RESET_OFF = 16'h0000,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PEND_W = $clog2(MAX_PEND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redir_i,
  input  seg_t              redir_seg_i,
  input  off_t              redir_off_i,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [CNT_W-1:0]  occ_i,
  output seg_t              seg_o,
  output off_t              off_o,
  output logic              mem_req_o,
  output logic              push_o,
  output logic [PEND_W-1:0] live_o,
  output logic [PEND_W-1:0] total_o
);
  seg_t              seg_q;
  off_t              off_q;
  logic [PEND_W-1:0] live_q, total_q;
  logic [PEND_W:0]   room_sum;
  logic              accept, stale_rsp, live_rsp;

  always_comb begin
    room_sum  = (PEND_W+1)'(occ_i) + (PEND_W+1)'(live_q);
    mem_req_o = !redir_i
                && (room_sum < (PEND_W+1)'(DEPTH))
                && (total_q < PEND_W'(MAX_PEND));
    accept    = mem_req_o && mem_gnt_i;
    // responses return in order: stale ones drain first
    stale_rsp = mem_rvalid_i && (total_q != live_q);
    live_rsp  = mem_rvalid_i && (total_q == live_q);
    push_o    = live_rsp && !redir_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= RESET_SEG;
      off_q   <= RESET_OFF;
      live_q  <= '0;
      total_q <= '0;
    end else begin
      total_q <= total_q + PEND_W'(accept) - PEND_W'(mem_rvalid_i);
      if (redir_i) begin
        seg_q  <= redir_seg_i;
        off_q  <= redir_off_i;
        live_q <= '0;  // everything outstanding turns stale
      end else begin
        if (accept) off_q <= off_q + 1'b1;
        live_q <= live_q + PEND_W'(accept) - PEND_W'(live_rsp);
      end
    end
  end

  assign seg_o   = seg_q;
  assign off_o   = off_q;
  assign live_o  = live_q;
  assign total_o = total_q;

  logic unused_stale;
  assign unused_stale = stale_rsp;
endmodule

// File: rtl/ipq_prefetch_unit.sv
module ipq_prefetch_unit
  import ipq_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned MAX_PEND  = 16,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        redir_i,
  input  logic [15:0] redir_seg_i,
  input  logic [15:0] redir_off_i,
  output logic        mem_req_o,
  output logic [19:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        pop_valid_o,
  output logic [7:0]  pop_data_o,
  input  logic        pop_ready_i
);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned PEND_W = $clog2(MAX_PEND + 1);

  seg_t              cur_seg;
  off_t              cur_off;
  logic              fifo_push;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [PEND_W-1:0] live_cnt, total_cnt;
  byte_t             head_byte;

  ipq_fetch_ctrl #(
    .DEPTH(DEPTH), .MAX_PEND(MAX_PEND),
    .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .redir_i, .redir_seg_i, .redir_off_i,
    .mem_gnt_i, .mem_rvalid_i,
    .occ_i   (fifo_cnt),
    .seg_o   (cur_seg),
    .off_o   (cur_off),
    .mem_req_o,
    .push_o  (fifo_push),
    .live_o  (live_cnt),
    .total_o (total_cnt)
  );

  ipq_addr_gen u_agen (
    .seg_i   (cur_seg),
    .off_i   (cur_off),
    .paddr_o (mem_addr_o)
  );

  assign pop_valid_o = (fifo_cnt != '0) && !redir_i;

  ipq_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (redir_i),
    .push_i  (fifo_push),
    .din_i   (mem_rdata_i),
    .pop_i   (pop_valid_o && pop_ready_i),
    .dout_o  (head_byte),
    .cnt_o   (fifo_cnt)
  );

  assign pop_data_o = head_byte;
endmodule

// File: rtl/ipq_prefetch_unit_chk.sv
module ipq_prefetch_unit_chk #(
  parameter int unsigned DEPTH    = 6,
  parameter int unsigned MAX_PEND = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned PEND_W = $clog2(MAX_PEND + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              redir_i,
  input logic              mem_req_o,
  input logic [19:0]       mem_addr_o,
  input logic              mem_gnt_i,
  input logic              mem_rvalid_i,
  input logic              pop_valid_o,
  input logic [7:0]        pop_data_o,
  input logic              pop_ready_i,
  input logic [15:0]       off_i,
  input logic [CNT_W-1:0]  occ_i,
  input logic [PEND_W-1:0] live_i,
  input logic [PEND_W-1:0] total_i
);
  a_r5_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= CNT_W'(DEPTH));

  a_r5_req_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((32'(occ_i) + 32'(live_i)) < DEPTH) && (32'(total_i) < MAX_PEND));

  a_r3_off_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> off_i == $past(off_i) + 16'd1);

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (redir_i || $stable(mem_addr_o)));

  a_r4_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_valid_o && !pop_ready_i) |=> (redir_i || (pop_valid_o && $stable(pop_data_o))));

  a_r6_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> occ_i == '0);

  a_r7_stale_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rvalid_i && total_i != live_i) |=> occ_i <= $past(occ_i));

  a_r8_no_pop_on_redir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |-> !pop_valid_o);
endmodule

bind ipq_prefetch_unit ipq_prefetch_unit_chk #(.DEPTH(DEPTH), .MAX_PEND(MAX_PEND)) u_chk (
  .clk_i, .rst_ni, .redir_i, .mem_req_o, .mem_addr_o, .mem_gnt_i,
  .mem_rvalid_i, .pop_valid_o, .pop_data_o, .pop_ready_i,
  .off_i   (cur_off),
  .occ_i   (fifo_cnt),
  .live_i  (live_cnt),
  .total_i (total_cnt)
);

// File: tb/tb_ipq_prefetch_unit.sv
module tb_ipq_prefetch_unit;
  localparam int DEPTH    = 6;
  localparam int MAX_PEND = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        redir_i = 1'b0;
  logic [15:0] redir_seg_i = '0, redir_off_i = '0;
  logic        mem_req_o;
  logic [19:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic        pop_valid_o;
  logic [7:0]  pop_data_o;
  logic        pop_ready_i = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ipq_prefetch_unit #(.DEPTH(DEPTH), .MAX_PEND(MAX_PEND),
                      .RESET_SEG(16'hFFFF), .RESET_OFF(16'h0000)) dut (
    .clk_i(clk), .rst_ni, .redir_i, .redir_seg_i, .redir_off_i,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .pop_valid_o, .pop_data_o, .pop_ready_i);

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int unsigned m_seg = 32'hFFFF, m_off = 0;
  int live = 0, tot = 0;
  logic [7:0]  q[$];
  logic [19:0] mq[$];
  bit was_redir = 0;
  logic [19:0] last_addr;

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit br, input logic [15:0] s, input logic [15:0] o, input bit rdy);
    bit gnt, rv, ereq, epv, acc, popped;
    logic [7:0]  rd, epd;
    logic [19:0] eaddr;
    @(negedge clk);
    gnt = $urandom_range(0, 9) < 7;
    rv  = (mq.size() > 0) && ($urandom_range(0, 9) < 6);
    rd  = rv ? mbyte(mq[0]) : 8'h00;
    redir_i = br; redir_seg_i = s; redir_off_i = o;
    mem_gnt_i = gnt; mem_rvalid_i = rv; mem_rdata_i = rd; pop_ready_i = rdy;
    #1;
    ereq  = !br && (q.size() + live < DEPTH) && (tot < MAX_PEND);
    eaddr = 20'((m_seg << 4) + m_off);
    epv   = (q.size() > 0) && !br;
    epd   = epv ? q[0] : 8'h00;
    chk(mem_req_o === ereq, "R5 fetch request", 32'(mem_req_o), 32'(ereq));
    if (ereq) chk(mem_addr_o === eaddr, "R2 R3 fetch address", 32'(mem_addr_o), 32'(eaddr));
    chk(pop_valid_o === epv,
        br ? "R8 pop blocked by redirect" : (was_redir ? "R6 queue flushed" : "R4 pop valid"),
        32'(pop_valid_o), 32'(epv));
    if (epv) chk(pop_data_o === epd, "R4 R7 pop data order", 32'(pop_data_o), 32'(epd));
    last_addr = mem_addr_o;
    @(posedge clk);
    acc    = ereq && gnt;
    popped = epv && rdy;
    if (acc) mq.push_back(eaddr);
    if (rv) void'(mq.pop_front());
    tot = tot + int'(acc) - int'(rv);
    if (br) begin
      q.delete();
      live  = 0;
      m_seg = s; m_off = o;
    end else begin
      if (popped) void'(q.pop_front());
      if (rv) begin
        if (tot + int'(rv) - int'(acc) > live) begin
          // stale response, discarded
        end else begin
          q.push_back(rd);
          live--;
        end
      end
      if (acc) begin
        live++;
        m_off = (m_off + 1) & 32'hFFFF;
      end
    end
    was_redir = br;
  endtask

  task automatic rnd(input int n, input int br_pct, input int rdy_pct);
    for (int i = 0; i < n; i++)
      cycle($urandom_range(0, 99) < br_pct, 16'($urandom), 16'($urandom),
            $urandom_range(0, 99) < rdy_pct);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(pop_valid_o === 1'b0, "R1 empty after reset", 32'(pop_valid_o), 0);
    chk(mem_req_o === 1'b1, "R1 request after reset", 32'(mem_req_o), 1);
    chk(mem_addr_o === 20'hFFFF0, "R1 reset address", 32'(mem_addr_o), 32'h0FFFF0);

    rnd(60, 0, 50);                          // R2 20-bit wrap past FFFFF
    cycle(1'b1, 16'h4321, 16'h1000, 1'b1);
    cycle(1'b0, 16'h0, 16'h0, 1'b1);
    chk(last_addr === 20'h44210, "R2 worked example", 32'(last_addr), 32'h44210);
    rnd(40, 0, 60);
    cycle(1'b1, 16'h0000, 16'hFFFE, 1'b1);  // R3 offset wrap
    rnd(40, 0, 60);
    rnd(40, 0, 0);                           // R5 fill with consumer stalled
    cycle(1'b1, 16'h1234, 16'h0042, 1'b1);  // R8 redirect while head offered
    rnd(10, 0, 0);
    cycle(1'b1, 16'h2000, 16'h0000, 1'b1);  // R7 redirect with reads in flight
    cycle(1'b1, 16'h3000, 16'h0000, 1'b1);
    rnd(4000, 6, 70);
    rnd(500, 20, 30);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule